// File: doc/BRIEF.md
# Word-to-Page Byte Packer

The packer accepts a stream of 24-bit words over a valid/ready handshake. It sends each word out as three bytes over a second valid/ready handshake. A byte address and an end-of-page strobe travel with each byte, so a downstream page programmer can commit a 64-byte page at every strobe.

Three bytes per word do not divide evenly into 64-byte pages. A word's bytes may therefore fall on both sides of a page boundary. The packer keeps the bytes of a word that have not yet been sent, even across a page edge. Every 64 words, which is 192 bytes or three pages, the byte stream lines up with a page edge again.

A stream ends with the word flagged as last. The packer then adds zero bytes until the output reaches the next 192-byte group boundary, so the memory is always written in whole 64-word groups. The next stream starts again at the configured base address.

The control is a three-state machine:
- `ST_IDLE`: no word is held and input is accepted.
- `ST_SEND`: the lanes of the held word are presented.
- `ST_PAD`: zero fill bytes are presented.

Its transitions are:
- IDLE→SEND: a word is accepted.
- SEND→SEND: the high lane is taken while the next word is accepted in the same cycle.
- SEND→IDLE: the high lane is taken and no word is waiting, or the last word ends exactly on a group edge.
- SEND→PAD: the last word ends inside a group.
- PAD→IDLE: the final byte of the group is taken.

Top module: `page_byte_packer`

## Requirements
- R1: The bytes of each accepted word leave in the order `in_word[7:0]`, then `in_word[15:8]`, then `in_word[23:16]`, as consecutive bytes of the output stream.
- R2: Counting output bytes from 0 since reset, `out_page_end` is high together with byte k exactly when k mod 64 equals 63. It is never high while `out_valid` is low.
- R3: A word whose bytes cross a page edge keeps its remaining bytes. For example, word 21 of a group sends its low byte as the last byte of the first page and its middle and high bytes as the first bytes of the second page.
- R4: The first byte of every stream carries address `BASE_ADDR`. Each following byte carries the previous address plus one.
- R5: After the last word, bytes of value 0x00 follow until the stream length is 192 × (floor((N−1)/64) + 1) bytes for N input words.
- R6: When the last word completes a 64-word group, no fill byte is sent, and the following stream starts again at `BASE_ADDR`.
- R7: While `out_valid` is high and `out_ready` is low, `out_byte`, `out_addr` and `out_page_end` hold their values. No byte is lost or repeated.
- R8: `in_ready` is high only when no word is held, or when the high byte of a non-last word is being taken in that cycle. It is low while fill bytes are sent. The cycle after a word is accepted, `out_valid` is high.
- R9: During and right after reset, `out_valid` and `out_page_end` are low and `in_ready` is high.
- R10: With input always valid and `out_ready` always high, the stream after the first byte has no idle cycle: one byte per clock until the group boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is valid |
| in_ready | output | 1 | Packer accepts the input word this cycle |
| in_word | input | WORD_W | 24-bit input word |
| in_last | input | 1 | Marks the final word of a stream |
| out_valid | output | 1 | Output byte is valid |
| out_ready | input | 1 | Downstream takes the byte this cycle |
| out_byte | output | BYTE_W | Output byte |
| out_addr | output | ADDR_W | Byte address of `out_byte` |
| out_page_end | output | 1 | High with the last byte of a 64-byte page |

## Verification
A word accepted at a clock edge has its low byte on `out_byte` just after that edge, one register stage later. Each following byte appears just after the edge where the previous byte was taken. Address and page strobe are valid together with their byte, and the address returns to base just after the final byte of a stream is taken. The bench changes inputs shortly after the rising edge and samples every output at the falling edge, where the values for the coming handshake are already settled. It counts only bytes that are handshaken at the next rising edge.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_PAD  = 2'd2
    } pbp_state_e;

endpackage

// File: rtl/pbp_lane_mux.sv
module pbp_lane_mux #(
    parameter int WORD_W = 24,
    parameter int BYTE_W = 8,
    parameter int LANES  = WORD_W / BYTE_W,
    parameter int SEL_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [BYTE_W-1:0] lane
);

    logic [BYTE_W-1:0] lanes [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lanes[g] = word[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        lane = '0;
        for (int i = 0; i < LANES; i++) begin
            if (sel == SEL_W'(i)) begin
                lane = lanes[i];
            end
        end
    end

endmodule

// File: rtl/pbp_wrap_counter.sv
module pbp_wrap_counter #(
    parameter int MAXV = 63,
    parameter int W    = (MAXV > 0) ? $clog2(MAXV + 1) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= (cnt == W'(MAXV)) ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pbp_addr_gen.sv
module pbp_addr_gen #(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= BASE_ADDR;
        end else if (reload) begin
            addr <= BASE_ADDR;
        end else if (step) begin
            addr <= addr + 1'b1;
        end
    end

endmodule

// File: rtl/page_byte_packer.sv
module page_byte_packer
    import pbp_pkg::*;
#(
    parameter int                WORD_W      = 24,
    parameter int                BYTE_W      = 8,
    parameter int                PAGE_BYTES  = 64,
    parameter int                GROUP_WORDS = 64,
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_byte,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_page_end
);

    localparam int LANES       = WORD_W / BYTE_W;
    localparam int LANE_W      = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int GROUP_BYTES = GROUP_WORDS * LANES;
    localparam int PAGE_CW     = $clog2(PAGE_BYTES);
    localparam int GROUP_CW    = $clog2(GROUP_BYTES);

    pbp_state_e state_q, state_d;

    logic [WORD_W-1:0]   hold_q;
    logic                last_q;
    logic [LANE_W-1:0]   lane_q;
    logic [BYTE_W-1:0]   lane_byte;
    logic [PAGE_CW-1:0]  page_pos;
    logic [GROUP_CW-1:0] group_pos;

    logic fire;
    logic accept;
    logic lane_top;
    logic group_top;
    logic word_done;
    logic stream_end;

    // ---------------- byte lane selection ----------------
    pbp_lane_mux #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W)
    ) u_lane_mux (
        .word (hold_q),
        .sel  (lane_q),
        .lane (lane_byte)
    );

    // ---------------- position in page and in group ----------------
    pbp_wrap_counter #(
        .MAXV (PAGE_BYTES - 1),
        .W    (PAGE_CW)
    ) u_page_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fire),
        .cnt   (page_pos)
    );

    pbp_wrap_counter #(
        .MAXV (GROUP_BYTES - 1),
        .W    (GROUP_CW)
    ) u_group_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (fire),
        .cnt   (group_pos)
    );

    // ---------------- byte address ----------------
    pbp_addr_gen #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_addr_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (stream_end),
        .step   (fire),
        .addr   (out_addr)
    );

    // ---------------- control decode ----------------
    assign fire       = out_valid && out_ready;
    assign accept     = in_valid && in_ready;
    assign lane_top   = (lane_q == LANE_W'(LANES - 1));
    assign group_top  = (group_pos == GROUP_CW'(GROUP_BYTES - 1));
    assign word_done  = (state_q == ST_SEND) && fire && lane_top;
    assign stream_end = (word_done && last_q && group_top)
                     || ((state_q == ST_PAD) && fire && group_top);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_SEND;
                end
            end
            ST_SEND: begin
                if (word_done) begin
                    if (last_q) begin
                        state_d = group_top ? ST_IDLE : ST_PAD;
                    end else begin
                        state_d = accept ? ST_SEND : ST_IDLE;
                    end
                end
            end
            ST_PAD: begin
                if (fire && group_top) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_byte  = '0;
        unique case (state_q)
            ST_IDLE: begin
                in_ready = 1'b1;
            end
            ST_SEND: begin
                out_valid = 1'b1;
                out_byte  = lane_byte;
                in_ready  = lane_top && out_ready && !last_q;
            end
            ST_PAD: begin
                out_valid = 1'b1;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
        out_page_end = out_valid && (page_pos == PAGE_CW'(PAGE_BYTES - 1));
    end

    // ---------------- held word and lane pointer ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            last_q <= 1'b0;
            lane_q <= '0;
        end else if (accept) begin
            hold_q <= in_word;
            last_q <= in_last;
            lane_q <= '0;
        end else if ((state_q == ST_SEND) && fire && !lane_top) begin
            lane_q <= lane_q + 1'b1;
        end
    end

endmodule

// File: rtl/pbp_checker.sv
module pbp_checker #(
    parameter int                ADDR_W     = 16,
    parameter int                BYTE_W     = 8,
    parameter int                PAGE_BYTES = 64,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_byte,
    input logic [ADDR_W-1:0] out_addr,
    input logic              out_page_end
);

    localparam int PW = $clog2(PAGE_BYTES);

    logic [PW-1:0] seen_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_pos <= '0;
        end else if (out_valid && out_ready) begin
            seen_pos <= seen_pos + 1'b1;
        end
    end

    // R2: strobe exactly on every 64th handshaken byte
    a_r2_page_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_page_end == (seen_pos == PW'(PAGE_BYTES - 1))));

    // R2: no strobe without a byte
    a_r2_strobe_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_page_end);

    // R4: address steps by one or returns to base at a stream end
    a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready) |=>
            ((out_addr == $past(out_addr) + 1'b1) || (out_addr == BASE_ADDR)));

    // R7: a refused byte is held unchanged
    a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_byte) && $stable(out_addr) && $stable(out_page_end)));

    // R8: while a byte is shown, input is taken only if that byte is taken too
    a_r8_ready_coupled: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && out_valid) |-> out_ready);

    // R8: an accepted word is presented on the next cycle
    a_r8_accept_presents: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

endmodule

bind page_byte_packer pbp_checker #(
    .ADDR_W     (ADDR_W),
    .BYTE_W     (BYTE_W),
    .PAGE_BYTES (PAGE_BYTES),
    .BASE_ADDR  (BASE_ADDR)
) u_pbp_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_byte     (out_byte),
    .out_addr     (out_addr),
    .out_page_end (out_page_end)
);

// File: tb/page_byte_packer_bench.sv
module page_byte_packer_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          ADDR_W     = 16;
    localparam logic [15:0] BASE       = 16'h4000;
    localparam int          NVEC       = 7;
    // {word count, ready mode, input gap mode}
    localparam int VEC [NVEC][3] = '{
        '{1,   0, 0},
        '{22,  0, 0},
        '{64,  0, 0},
        '{65,  1, 0},
        '{43,  2, 1},
        '{128, 1, 1},
        '{7,   2, 0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_word = '0;
    logic        in_last = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_byte;
    logic [15:0] out_addr;
    logic        out_page_end;

    page_byte_packer #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE)
    ) u_page_byte_packer (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .in_word      (in_word),
        .in_last      (in_last),
        .out_valid    (out_valid),
        .out_ready    (out_ready),
        .out_byte     (out_byte),
        .out_addr     (out_addr),
        .out_page_end (out_page_end)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rmode = 0;
    int mon_s = 0;
    int mon_n = 0;
    int mon_k = 0;
    int first_fire = 0;
    int last_fire = 0;
    bit prev_stall = 1'b0;
    logic [7:0]  prev_byte = '0;
    logic [15:0] prev_addr = '0;
    logic        prev_pe = 1'b0;

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] wordval(input int s, input int i);
        logic [7:0] hi;
        logic [7:0] mid;
        logic [7:0] lo;
        hi  = 8'(i) ^ 8'h5A;
        mid = 8'(s * 8 + 3);
        lo  = 8'(i + 1);
        return {hi, mid, lo};
    endfunction

    function automatic logic [7:0] exp_byte(input int s, input int n, input int k);
        logic [23:0] w;
        if (k < 3 * n) begin
            w = wordval(s, k / 3);
            return w[(k % 3) * 8 +: 8];
        end
        return 8'h00;
    endfunction

    function automatic int exp_total(input int n);
        return 192 * ((n - 1) / 64 + 1);
    endfunction

    // downstream ready pattern
    initial forever begin
        @(posedge clk);
        #1;
        case (rmode)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            2: out_ready = ((cyc ^ (cyc >> 2)) & 1) == 1;
            default: out_ready = 1'b0;
        endcase
    end

    // output monitor, sampled at the falling edge
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (prev_stall && out_valid) begin
                check(out_byte == prev_byte && out_addr == prev_addr && out_page_end == prev_pe,
                      "R7", "held byte/addr/strobe", {out_byte, out_addr}, {prev_byte, prev_addr});
            end
            if (!out_valid) begin
                check(!out_page_end, "R2", "strobe without byte", out_page_end, 0);
            end
            if (out_valid && out_ready) begin
                // R1 R3 R5: byte value by position
                check(out_byte == exp_byte(mon_s, mon_n, mon_k), (mon_k < 3 * mon_n) ? "R1/R3" : "R5",
                      $sformatf("byte %0d", mon_k), out_byte, exp_byte(mon_s, mon_n, mon_k));
                check(out_addr == BASE + 16'(mon_k), "R4", $sformatf("addr of byte %0d", mon_k),
                      out_addr, BASE + 16'(mon_k));
                check(out_page_end == ((mon_k % 64) == 63), "R2", $sformatf("strobe at byte %0d", mon_k),
                      out_page_end, (mon_k % 64) == 63);
                if (mon_k >= 3 * mon_n) begin
                    check(!in_ready, "R8", "in_ready during fill", in_ready, 0);
                end
                if (mon_k == 0) first_fire = cyc;
                last_fire = cyc;
                mon_k++;
            end
            prev_stall = out_valid && !out_ready;
            prev_byte  = out_byte;
            prev_addr  = out_addr;
            prev_pe    = out_page_end;
        end else begin
            prev_stall = 1'b0;
        end
    end

    task automatic send_word(input logic [23:0] w, input logic last);
        bit hs;
        in_valid = 1'b1;
        in_word  = w;
        in_last  = last;
        do begin
            @(negedge clk);
            hs = in_ready;
            @(posedge clk);
            #1;
        end while (!hs);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run_stream(input int s, input int n, input int rm, input int gm);
        int t;
        mon_s = s;
        mon_n = n;
        mon_k = 0;
        rmode = rm;
        for (int i = 0; i < n; i++) begin
            if (gm != 0 && (i % 5) == 2) begin
                @(posedge clk);
                #1;
            end
            send_word(wordval(s, i), i == n - 1);
        end
        t = 0;
        while (mon_k < exp_total(n) && t < 20000) begin
            @(posedge clk);
            t++;
        end
        repeat (10) @(posedge clk);
        #1;
        check(mon_k == exp_total(n), (n % 64 == 0) ? "R6" : "R5",
              $sformatf("stream %0d byte count", s), mon_k, exp_total(n));
        if (rm == 0 && gm == 0) begin
            check(last_fire - first_fire == exp_total(n) - 1, "R10",
                  $sformatf("stream %0d cycle span", s), last_fire - first_fire, exp_total(n) - 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && in_ready && !out_page_end, "R9", "state in reset",
              {out_valid, in_ready, out_page_end}, 3'b010);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready && !out_page_end, "R9", "state after reset",
              {out_valid, in_ready, out_page_end}, 3'b010);
        @(posedge clk);
        #1;

        for (int v = 0; v < NVEC; v++) begin
            run_stream(v + 1, VEC[v][0], VEC[v][1], VEC[v][2]);
        end

        // reset while a word is held and stalled
        rmode = 3;
        @(posedge clk);
        #1;
        mon_s = 20;
        mon_n = 1;
        mon_k = 0;
        send_word(wordval(20, 0), 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid && out_addr == BASE && out_byte == wordval(20, 0)[7:0], "R7",
              "stalled first byte", {out_valid, out_addr}, {1'b1, BASE});
        check(!in_ready, "R8", "in_ready while word held", in_ready, 0);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready && !out_page_end, "R9", "mid-stream reset",
              {out_valid, in_ready, out_page_end}, 3'b010);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        run_stream(21, 20, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule